// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the time base of a CAN node. A programmable prescaler divides the clock into time quanta. Each nominal bit is then stepped through four segments in a fixed order: a one-quantum sync segment, a propagation segment, phase 1 and phase 2. The block strobes once at the sample point, which is the end of phase 1, and once at the bit boundary, which is the end of phase 2. It also latches the receive level at each sample point.

The receive line passes through a synchronizer. Every recessive-to-dominant transition is then used to keep the local bit clock aligned to the bus. When the bus is idle, a falling edge restarts the bit with a hard synchronization. Otherwise the edge makes a bounded resynchronization: phase 1 is stretched or phase 2 is cut short by at most the programmed jump width.

All timing fields arrive in one packed configuration word, each field encoded as its value minus one. The word is captured only while the enable input is low. While the block is disabled it sits idle, and it starts fresh when enable rises. Frame decoding, bit stuffing and error handling belong to the logic that consumes the strobes.

Top module: `can_btg_top`

## Requirements
- R1: While enabled, `tq_tick` pulses for one cycle every D clock cycles, where D is the prescale field plus one (1 to 128).
- R2: A bit lasts 1 + P + A + B quanta, where P, A and B are the propagation, phase 1 and phase 2 fields plus one. `bit_stb` pulses in the last cycle of the bit. `seg_code` steps 0 (sync), 1 (propagation), 2 (phase 1), 3 (phase 2), then back to 0.
- R3: `sample_stb` pulses in the last cycle of phase 1, which is (1 + P + A) x D cycles after the preceding `bit_stb`, and never in the same cycle as `bit_stb`. From the next cycle, `rx_sampled` holds the synchronized receive level taken at that point.
- R4: The configuration word is laid out as follows: bits [6:0] prescale-1, [9:7] propagation-1, [12:10] phase 1-1, [15:13] phase 2-1, [17:16] jump width-1. It is captured only while `enable` is low. Changes made while `enable` is high have no effect on the bit timing.
- R5: While `enable` is low there are no `tq_tick`, `sample_stb` or `bit_stb` pulses. In that state `seg_code` is 0, `bus_idle` is 1 and `rx_sampled` is 1.
- R6: `rx_in` passes through a two-flop synchronizer. A falling edge acts at the third rising clock after `rx_in` changes. If `bus_idle` is 1 at that point, the edge causes a hard synchronization: the prescaler restarts, the bit resumes at the start of the propagation segment, `bus_idle` drops, and the next `sample_stb` comes (P + A) x D cycles after that clock.
- R7: A falling edge that acts during the sync segment leaves the bit length unchanged.
- R8: A falling edge during the propagation segment or phase 1 lengthens phase 1 by min(E, J) quanta. E is the number of quanta since the sync segment ended, counting the quantum that holds the edge. J is the jump width field plus one.
- R9: A falling edge during phase 2 shortens phase 2 by min(E, J) quanta. E is the number of phase 2 quanta that remain after the quantum holding the edge.
- R10: Only the first falling edge in a bit adjusts that bit; later edges in the same bit are ignored. Rising edges never adjust timing.
- R11: `bus_idle` returns to 1 at the end of the 11th consecutive bit sampled recessive (1). A bit sampled dominant restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the timing unit; configuration is captured while low |
| cfg_word | input | 18 | Packed timing fields, each encoded minus one |
| rx_in | input | 1 | Asynchronous receive line, 1 = recessive |
| tq_tick | output | 1 | One-cycle pulse at the end of each time quantum |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| bit_stb | output | 1 | One-cycle pulse at the end of each bit |
| rx_sampled | output | 1 | Receive level captured at the last sample point |
| bus_idle | output | 1 | Bus seen idle; the next falling edge hard-synchronizes |
| seg_code | output | 2 | Current segment: 0 sync, 1 propagation, 2 phase 1, 3 phase 2 |

## Verification
Free-running bits are measured under three configurations: a divide of 1, a divide of 4 and the full divide of 128, each with a different segment mix. Comparing the bit period and the sample offset across these configurations separates a prescaler fault from a segment-length fault. Single falling edges are placed in the sync segment, in propagation, in phase 1 and at two positions in phase 2. Each placement exercises a different correction rule, the jump-width cap, and the off-by-one in the phase 2 error. A pair of edges within one bit checks the one-adjustment-per-bit rule, and an edge on an idle bus checks the hard-synchronization restart point. A dominant bit followed by a recessive run checks when the idle state returns.

// File: rtl/can_btg_pkg.sv
package can_btg_pkg;

   // Segment order inside one nominal bit; the numeric codes are visible on seg_code.
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;

endpackage

// File: rtl/can_btg_rxsync.sv
module can_btg_rxsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_s,
   output logic rx_fall
);

   logic rx_prev;

   // Synchronizer chain; every stage resets to recessive.
   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         logic q;
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b1;
               else        q <= rx_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b1;
               else        q <= g_stage[g-1].q;
            end
         end
      end
   endgenerate

   assign rx_s = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= rx_s;
   end

   // Recessive-to-dominant transition of the synchronized line.
   assign rx_fall = rx_prev & ~rx_s;

endmodule

// File: rtl/can_btg_prescale.sv
module can_btg_prescale #(
   parameter int BRP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [BRP_W-1:0] div_m1,
   output logic             tick
);

   logic [BRP_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || restart)  cnt <= '0;
      else if (cnt == div_m1)    cnt <= '0;
      else                       cnt <= cnt + BRP_W'(1);
   end

   assign tick = run & ~restart & (cnt == div_m1);

endmodule

// File: rtl/can_btg_seq.sv
module can_btg_seq
   import can_btg_pkg::*;
#(
   parameter int SEG_W     = 3,
   parameter int SJW_W     = 2,
   parameter int IDLE_BITS = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             rx_s,
   input  logic             rx_fall,
   input  logic [SEG_W-1:0] prop_m1,
   input  logic [SEG_W-1:0] ph1_m1,
   input  logic [SEG_W-1:0] ph2_m1,
   input  logic [SJW_W-1:0] sjw_m1,
   output logic             hard_sync,
   output logic             sample_stb,
   output logic             bit_stb,
   output logic             rx_sampled,
   output logic             bus_idle,
   output seg_e             seg
);

   localparam int LEN_W = SEG_W + 2;
   localparam int IC_W  = $clog2(IDLE_BITS + 1);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
   localparam logic [IC_W-1:0]  IDLE_LAST = IC_W'(IDLE_BITS - 1);

   logic [LEN_W-1:0] qcnt, ext, shr;
   logic             done;
   logic [IC_W-1:0]  idle_cnt;

   logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
   logic [LEN_W-1:0] err, ecap, ext_eff, shr_eff, ph1_lim, ph2_lim;
   logic             resync, last_q;

   assign prop_len = {{(LEN_W-SEG_W){1'b0}}, prop_m1} + ONE;
   assign ph1_len  = {{(LEN_W-SEG_W){1'b0}}, ph1_m1}  + ONE;
   assign ph2_len  = {{(LEN_W-SEG_W){1'b0}}, ph2_m1}  + ONE;
   assign sjw_len  = {{(LEN_W-SJW_W){1'b0}}, sjw_m1}  + ONE;

   assign hard_sync = run & bus_idle & rx_fall;
   assign resync    = run & ~bus_idle & rx_fall & ~done & (seg != SEG_SYNC);

   // Phase error in quanta, by the segment in which the edge lands.
   always_comb begin
      err = '0;
      unique case (seg)
         SEG_PROP: err = qcnt + ONE;
         SEG_PH1:  err = prop_len + qcnt + ONE;
         SEG_PH2:  err = ph2_len - qcnt - ONE;
         default:  err = '0;
      endcase
   end

   assign ecap    = (err > sjw_len) ? sjw_len : err;
   assign ext_eff = (resync && (seg == SEG_PROP || seg == SEG_PH1)) ? ecap : ext;
   assign shr_eff = (resync && seg == SEG_PH2) ? ecap : shr;
   assign ph1_lim = ph1_len + ext_eff;
   assign ph2_lim = ph2_len - shr_eff;

   always_comb begin
      last_q = 1'b1;
      unique case (seg)
         SEG_SYNC: last_q = 1'b1;
         SEG_PROP: last_q = (qcnt == prop_len - ONE);
         SEG_PH1:  last_q = (qcnt == ph1_lim - ONE);
         SEG_PH2:  last_q = ((qcnt + ONE) >= ph2_lim);
         default:  last_q = 1'b1;
      endcase
   end

   assign sample_stb = tick & last_q & (seg == SEG_PH1);
   assign bit_stb    = tick & last_q & (seg == SEG_PH2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg        <= SEG_SYNC;
         qcnt       <= '0;
         ext        <= '0;
         shr        <= '0;
         done       <= 1'b0;
         bus_idle   <= 1'b1;
         idle_cnt   <= '0;
         rx_sampled <= 1'b1;
      end else if (!run) begin
         seg        <= SEG_SYNC;
         qcnt       <= '0;
         ext        <= '0;
         shr        <= '0;
         done       <= 1'b0;
         bus_idle   <= 1'b1;
         idle_cnt   <= '0;
         rx_sampled <= 1'b1;
      end else if (hard_sync) begin
         seg      <= SEG_PROP;
         qcnt     <= '0;
         ext      <= '0;
         shr      <= '0;
         done     <= 1'b0;
         bus_idle <= 1'b0;
         idle_cnt <= '0;
      end else begin
         if (resync) begin
            done <= 1'b1;
            ext  <= ext_eff;
            shr  <= shr_eff;
         end
         if (tick) begin
            if (last_q) begin
               qcnt <= '0;
               unique case (seg)
                  SEG_SYNC: seg <= SEG_PROP;
                  SEG_PROP: seg <= SEG_PH1;
                  SEG_PH1: begin
                     seg        <= SEG_PH2;
                     rx_sampled <= rx_s;
                  end
                  SEG_PH2: begin
                     seg  <= SEG_SYNC;
                     ext  <= '0;
                     shr  <= '0;
                     done <= 1'b0;
                     if (rx_sampled) begin
                        if (idle_cnt == IDLE_LAST) bus_idle <= 1'b1;
                        else                       idle_cnt <= idle_cnt + IC_W'(1);
                     end else begin
                        idle_cnt <= '0;
                     end
                  end
                  default: seg <= SEG_SYNC;
               endcase
            end else begin
               qcnt <= qcnt + ONE;
            end
         end
      end
   end

endmodule

// File: rtl/can_btg_top.sv
module can_btg_top
   import can_btg_pkg::*;
#(
   parameter int BRP_W       = 7,
   parameter int SEG_W       = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_BITS   = 11,
   localparam int CFG_W      = BRP_W + 3*SEG_W + SJW_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             rx_in,
   output logic             tq_tick,
   output logic             sample_stb,
   output logic             bit_stb,
   output logic             rx_sampled,
   output logic             bus_idle,
   output logic [1:0]       seg_code
);

   localparam int OFF_PROP = BRP_W;
   localparam int OFF_PH1  = OFF_PROP + SEG_W;
   localparam int OFF_PH2  = OFF_PH1 + SEG_W;
   localparam int OFF_SJW  = OFF_PH2 + SEG_W;

   generate
      if (BRP_W < 1) begin : g_chk_brp
         $error("BRP_W must be at least 1");
      end
      if (SEG_W < 2) begin : g_chk_seg
         $error("SEG_W must be at least 2");
      end
      if (SJW_W < 1 || SJW_W > SEG_W) begin : g_chk_sjw
         $error("SJW_W must lie between 1 and SEG_W");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IDLE_BITS < 1) begin : g_chk_idle
         $error("IDLE_BITS must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic             rx_s, rx_fall, hard_sync;
   seg_e             seg;

   // Configuration follows the input only while the unit is disabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (!enable) cfg_q <= cfg_word;
   end

   can_btg_rxsync #(.STAGES(SYNC_STAGES)) u_rxsync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_in   (rx_in),
      .rx_s    (rx_s),
      .rx_fall (rx_fall)
   );

   can_btg_prescale #(.BRP_W(BRP_W)) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (enable),
      .restart (hard_sync),
      .div_m1  (cfg_q[OFF_PROP-1:0]),
      .tick    (tq_tick)
   );

   can_btg_seq #(
      .SEG_W     (SEG_W),
      .SJW_W     (SJW_W),
      .IDLE_BITS (IDLE_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (enable),
      .tick       (tq_tick),
      .rx_s       (rx_s),
      .rx_fall    (rx_fall),
      .prop_m1    (cfg_q[OFF_PROP +: SEG_W]),
      .ph1_m1     (cfg_q[OFF_PH1 +: SEG_W]),
      .ph2_m1     (cfg_q[OFF_PH2 +: SEG_W]),
      .sjw_m1     (cfg_q[OFF_SJW +: SJW_W]),
      .hard_sync  (hard_sync),
      .sample_stb (sample_stb),
      .bit_stb    (bit_stb),
      .rx_sampled (rx_sampled),
      .bus_idle   (bus_idle),
      .seg        (seg)
   );

   assign seg_code = seg;

endmodule

// File: rtl/can_btg_chk.sv
module can_btg_chk #(
   parameter int CFG_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             tq_tick,
   input logic             sample_stb,
   input logic             bit_stb,
   input logic             bus_idle,
   input logic [1:0]       seg_code,
   input logic [CFG_W-1:0] cfg_q
);

   // R1: segment strobes only ever come on a quantum boundary.
   p_strobe_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb || bit_stb) |-> tq_tick);

   // R2: segments advance one step at a time; a hard sync may jump to propagation.
   p_seg_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && seg_code != $past(seg_code))
      |-> (seg_code == $past(seg_code) + 2'd1) || (seg_code == 2'd1));

   // R2: after the bit boundary the next bit opens with sync (or a hard sync).
   p_bit_to_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && enable) |=> (!enable || seg_code == 2'd0 || seg_code == 2'd1));

   // R3: the sample point hands over to phase 2.
   p_sample_to_ph2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && enable) |=> (!enable || seg_code == 2'd3 || seg_code == 2'd1));

   // R3: sample point and bit boundary never coincide.
   p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !bit_stb);

   // R4: captured configuration is frozen while running.
   p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(cfg_q));

   // R5: disabled unit is silent and reports an idle bus.
   p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!tq_tick && !sample_stb && !bit_stb));

   p_idle_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> bus_idle);

endmodule

bind can_btg_top can_btg_chk #(.CFG_W(CFG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .tq_tick    (tq_tick),
   .sample_stb (sample_stb),
   .bit_stb    (bit_stb),
   .bus_idle   (bus_idle),
   .seg_code   (seg_code),
   .cfg_q      (cfg_q)
);

// File: tb/can_btg_top_bench.sv
module can_btg_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [17:0] cfg_word = '0;
   logic        rx_in = 1'b1;
   logic        tq_tick, sample_stb, bit_stb, rx_sampled, bus_idle;
   logic [1:0]  seg_code;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   can_btg_top u_can_btg_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .cfg_word   (cfg_word),
      .rx_in      (rx_in),
      .tq_tick    (tq_tick),
      .sample_stb (sample_stb),
      .bit_stb    (bit_stb),
      .rx_sampled (rx_sampled),
      .bus_idle   (bus_idle),
      .seg_code   (seg_code)
   );

   // Field layout of R4: lengths are given as real quanta counts, encoded minus one.
   function automatic logic [17:0] pack(int div, int prop, int ph1, int ph2, int sjw);
      return {2'(sjw - 1), 3'(ph2 - 1), 3'(ph1 - 1), 3'(prop - 1), 7'(div - 1)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_bit(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_stb && n < 5000);
   endtask

   task automatic apply_cfg(input logic [17:0] w);
      @(negedge clk);
      enable = 1'b0;
      cfg_word = w;
      repeat (3) @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic t_reset;
      check("R5 reset tq_tick", int'(tq_tick), 0);
      check("R5 reset strobes", int'(sample_stb | bit_stb), 0);
      check("R5 reset seg_code", int'(seg_code), 0);
      check("R5 reset bus_idle", int'(bus_idle), 1);
      check("R5 reset rx_sampled", int'(rx_sampled), 1);
   endtask

   task automatic t_disabled;
      int pulses = 0;
      cfg_word = pack(1, 1, 4, 2, 1);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (i == 20) rx_in = 1'b0;
         if (i == 40) rx_in = 1'b1;
         if (tq_tick || sample_stb || bit_stb) pulses++;
      end
      check("R5 disabled pulses", pulses, 0);
      check("R5 disabled seg_code", int'(seg_code), 0);
      check("R5 disabled bus_idle", int'(bus_idle), 1);
      repeat (5) @(negedge clk);
   endtask

   task automatic t_tick(input int div);
      int n = 0;
      apply_cfg(pack(div, 2, 4, 3, 2));
      do begin @(negedge clk); n++; end while (!tq_tick && n < 500);
      n = 0;
      do begin @(negedge clk); n++; end while (!tq_tick && n < 500);
      check("R1 quantum period", n, div);
   endtask

   task automatic t_period(input int div, input int prop, input int ph1, input int ph2, input int sjw);
      int n, c, samp_at;
      apply_cfg(pack(div, prop, ph1, ph2, sjw));
      wait_bit(n);
      check("R2 seg_code at bit end", int'(seg_code), 3);
      c = 0;
      samp_at = -1;
      do begin
         @(negedge clk);
         c++;
         if (sample_stb && samp_at < 0) begin
            samp_at = c;
            check("R2 seg_code at sample point", int'(seg_code), 2);
         end
      end while (!bit_stb && c < 5000);
      check("R2 bit period", c, div * (1 + prop + ph1 + ph2));
      check("R3 sample offset", samp_at, div * (1 + prop + ph1));
      check("R3 recessive sampled", int'(rx_sampled), 1);
   endtask

   task automatic t_cfg_lock;
      int n;
      apply_cfg(pack(4, 2, 4, 3, 2));
      wait_bit(n);
      cfg_word = pack(1, 1, 1, 2, 1);
      wait_bit(n);
      wait_bit(n);
      check("R4 period after live cfg change", n, 40);
      cfg_word = pack(4, 2, 4, 3, 2);
   endtask

   task automatic t_hard_sync;
      int n, c;
      apply_cfg(pack(4, 2, 4, 3, 2));
      check("R6 idle before edge", int'(bus_idle), 1);
      wait_bit(n);
      rx_in = 1'b0;
      c = 0;
      do begin @(negedge clk); c++; end while (!sample_stb && c < 500);
      check("R6 hard sync to sample", c, 2 + (2 + 4) * 4);
      check("R6 idle cleared", int'(bus_idle), 0);
      @(negedge clk);
      check("R3 dominant sampled", int'(rx_sampled), 0);
      wait_bit(n);
      rx_in = 1'b1;
   endtask

   // Config in force: divide 4, prop 2, ph1 4, ph2 3, jump 2 -> 10 quanta, 40 cycles.
   // Edge in quantum q: rx_in drops 4q negedges after the bit_stb negedge.
   task automatic t_resync(input string req, input int q, input int q2, input int exp_len);
      int n, c;
      wait_bit(n);
      c = 0;
      if (q == 0) rx_in = 1'b0;
      do begin
         @(negedge clk);
         c++;
         if (c == 4 * q) rx_in = 1'b0;
         if (q2 >= 0 && c == 4 * q + 4) rx_in = 1'b1;
         if (q2 >= 0 && c == 4 * q2) rx_in = 1'b0;
      end while (!bit_stb && c < 500);
      rx_in = 1'b1;
      check(req, c, exp_len);
   endtask

   task automatic t_idle;
      int n, first;
      wait_bit(n);
      rx_in = 1'b0;
      wait_bit(n);
      rx_in = 1'b1;
      check("R11 dominant bit sampled", int'(rx_sampled), 0);
      first = -1;
      for (int k = 1; k <= 12; k++) begin
         wait_bit(n);
         @(negedge clk);
         if (bus_idle && first < 0) first = k;
      end
      check("R11 recessive bits to idle", first, 11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_tick(5);
      t_tick(1);
      t_period(4, 2, 4, 3, 2);
      t_period(1, 3, 2, 3, 1);
      t_period(128, 1, 4, 2, 1);
      t_cfg_lock();
      t_hard_sync();
      t_resync("R7 edge in sync", 0, -1, 40);
      t_resync("R8 edge in propagation", 1, -1, 44);
      t_resync("R8 edge in phase 1 capped", 4, -1, 48);
      t_resync("R9 edge early in phase 2", 7, -1, 32);
      t_resync("R9 edge in last quantum", 9, -1, 40);
      t_resync("R10 second edge ignored", 1, 4, 44);
      t_idle();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule